// File: doc/BRIEF.md
# Pipelined Round-Robin Bus Arbiter with Initiator Acquisition

This block serves a shared parallel bus that several masters use. Each master gets an initiator controller. The controller raises the master's request line, waits for a grant, watches the bus control lines, and begins a transaction by driving its frame line low. A central arbiter keeps a single grant line low at any time. It chooses among pending requests in round-robin order.

The arbiter does not wait for the bus to become free before it chooses the next owner. It can move the grant to a waiting master while another master is still transferring data. That master then starts on the clock edge right after it sees the bus idle. The hand-over therefore costs no separate arbitration cycle, and transactions from different masters can run back to back.

All bus control signals are active low. When nothing is pending, the grant parks on a default master.

Top module: `pipelined_bus_arbiter`

## Requirements
- R1: One clock edge after a master raises `xfer_pending` while it is idle and not starting, its `req_n` bit goes low. While its transaction runs, its `req_n` bit is high.
- R2: At most one `gnt_n` bit is low in any cycle, and no two masters drive their frame line low at the same time.
- R3: A new grant goes to the first pending requester in the cyclic order that starts just after the master most recently granted on request. That order runs through bit index 0 to NUM_MASTERS-1 and then wraps to 0. After reset, the search starts at index 0.
- R4: While one master's transaction is in progress, the grant can move to another requesting master.
- R5: A granted master starts only when `frame_n`, `irdy_n`, `trdy_n` and `devsel_n` are all high.
- R6: A master that holds the grant, has `xfer_pending` high and sees the bus idle drives its frame bit low on the very next clock edge.
- R7: If the master holding a requested grant lets its `req_n` go high, the arbiter moves the grant one edge after it sees that change. The grant goes to the next requester, or it parks if no request is pending.
- R8: A master whose grant was removed before the bus became idle does not drive its frame line low.
- R9: A running master keeps its frame bit low until the cycle in which `final_phase` is high. Its frame bit goes high on the following edge. The arbiter never ends a transaction.
- R10: During reset, and whenever no request is pending, the grant parks on master PARK_ID (default 0). A parked master with `xfer_pending` high may start on an idle bus without requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_pending | input | NUM_MASTERS | Per master: a transaction is waiting to be issued |
| final_phase | input | NUM_MASTERS | Per master: the current data phase is its last |
| irdy_n | input | 1 | Bus initiator-ready line, active low |
| trdy_n | input | 1 | Bus target-ready line, active low |
| devsel_n | input | 1 | Bus device-select line, active low |
| req_n | output | NUM_MASTERS | Per-master request lines, active low |
| gnt_n | output | NUM_MASTERS | Per-master grant lines from the arbiter, active low |
| frame_drv_n | output | NUM_MASTERS | Frame line as driven by each master, active low |
| frame_n | output | 1 | Resolved bus frame line, low when any master drives it |

## Verification
Every result in this block comes from a register, so each one appears on a known edge:
- A request shows up one edge after `xfer_pending`.
- A grant changes one edge after the arbiter sees the registered requests.
- A master's frame bit falls on the edge that follows the cycle in which it held the grant and saw the bus idle.

The bench changes inputs at the falling edge and samples 1 ns after the next rising edge. Each table row therefore states the outputs that the next edge must produce. One row holds the bus busy with `irdy_n` low after the frame line is released, to show that starting waits for that line. The directed tests check reset and hold `devsel_n` low for one cycle to show that the start slips by exactly that cycle.

// File: rtl/bus_arb_pkg.sv
`timescale 1ns/1ps
package bus_arb_pkg;
  // Position reached when stepping `step` places forward around a ring of n slots.
  function automatic int ring_pos(int base, int step, int n);
    return (base + step) % n;
  endfunction
endpackage

// File: rtl/bus_idle_detect.sv
`timescale 1ns/1ps
module bus_idle_detect #(
  parameter int NUM_MASTERS = 4
) (
  input  logic [NUM_MASTERS-1:0] frame_drv_n,
  input  logic                   irdy_n,
  input  logic                   trdy_n,
  input  logic                   devsel_n,
  output logic                   frame_n,
  output logic                   bus_idle
);
  // Open-drain style resolution: any low driver pulls the shared line low.
  assign frame_n  = &frame_drv_n;
  assign bus_idle = frame_n & irdy_n & trdy_n & devsel_n;
endmodule

// File: rtl/rr_grant_arb.sv
`timescale 1ns/1ps
module rr_grant_arb
  import bus_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int PARK_ID     = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req_n,
  output logic [NUM_MASTERS-1:0] gnt_n
);
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam logic [NUM_MASTERS-1:0] PARK_HOT = {{(NUM_MASTERS-1){1'b0}}, 1'b1} << PARK_ID;

  logic [NUM_MASTERS-1:0] req, gnt_q;
  logic [IDX_W-1:0]       last_q, pick;
  logic                   parked_q, hold, found;

  always_comb begin
    req   = ~req_n;
    hold  = !parked_q && (|(gnt_q & req));
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_MASTERS; k++) begin
      if (!found && req[ring_pos(int'(last_q), k, NUM_MASTERS)]) begin
        found = 1'b1;
        pick  = IDX_W'(ring_pos(int'(last_q), k, NUM_MASTERS));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q    <= PARK_HOT;
      last_q   <= IDX_W'(NUM_MASTERS-1);
      parked_q <= 1'b1;
    end else if (!hold) begin
      if (found) begin
        gnt_q    <= {{(NUM_MASTERS-1){1'b0}}, 1'b1} << pick;
        last_q   <= pick;
        parked_q <= 1'b0;
      end else begin
        gnt_q    <= PARK_HOT;
        parked_q <= 1'b1;
      end
    end
  end

  assign gnt_n = ~gnt_q;

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~gnt_n));

  // R7: a requested grant whose request vanished must move (or park) on the next edge.
  assert_drop_regrant_R7: assert property (@(posedge clk) disable iff (rst)
    (!parked_q && ((gnt_q & req) == '0)) |=> (!$stable(gnt_n) || parked_q));

  assert_idle_park_R10: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (gnt_n == ~PARK_HOT));
endmodule

// File: rtl/bus_initiator_ctl.sv
`timescale 1ns/1ps
module bus_initiator_ctl (
  input  logic clk,
  input  logic rst,
  input  logic xfer_pending,
  input  logic final_phase,
  input  logic gnt_n,
  input  logic bus_idle,
  output logic req_n,
  output logic frame_n
);
  logic frame_q, req_q, start;

  assign start = frame_q && xfer_pending && !gnt_n && bus_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b1;
      req_q   <= 1'b1;
    end else begin
      if (!frame_q)   frame_q <= final_phase;
      else if (start) frame_q <= 1'b0;
      req_q <= !(xfer_pending && frame_q && !start);
    end
  end

  assign frame_n = frame_q;
  assign req_n   = req_q;

  assert_req_off_busy_R1: assert property (@(posedge clk) disable iff (rst)
    !frame_q |=> req_q);

  // R5 and R8: a falling frame needs grant plus an idle bus in the cycle before.
  assert_start_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_q) |-> $past(bus_idle && !gnt_n));

  assert_hold_frame_R9: assert property (@(posedge clk) disable iff (rst)
    (!frame_q && !final_phase) |=> !frame_q);

  assert_no_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_q && xfer_pending && !gnt_n && bus_idle) |=> !frame_n);
endmodule

// File: rtl/pipelined_bus_arbiter.sv
`timescale 1ns/1ps
module pipelined_bus_arbiter #(
  parameter int NUM_MASTERS = 4,
  parameter int PARK_ID     = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] xfer_pending,
  input  logic [NUM_MASTERS-1:0] final_phase,
  input  logic                   irdy_n,
  input  logic                   trdy_n,
  input  logic                   devsel_n,
  output logic [NUM_MASTERS-1:0] req_n,
  output logic [NUM_MASTERS-1:0] gnt_n,
  output logic [NUM_MASTERS-1:0] frame_drv_n,
  output logic                   frame_n
);
  logic bus_idle;

  bus_idle_detect #(.NUM_MASTERS(NUM_MASTERS)) u_idle (
    .frame_drv_n (frame_drv_n),
    .irdy_n      (irdy_n),
    .trdy_n      (trdy_n),
    .devsel_n    (devsel_n),
    .frame_n     (frame_n),
    .bus_idle    (bus_idle)
  );

  rr_grant_arb #(.NUM_MASTERS(NUM_MASTERS), .PARK_ID(PARK_ID)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req_n (req_n),
    .gnt_n (gnt_n)
  );

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_init
    bus_initiator_ctl u_ctl (
      .clk          (clk),
      .rst          (rst),
      .xfer_pending (xfer_pending[m]),
      .final_phase  (final_phase[m]),
      .gnt_n        (gnt_n[m]),
      .bus_idle     (bus_idle),
      .req_n        (req_n[m]),
      .frame_n      (frame_drv_n[m])
    );
  end

  assert_single_owner_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~frame_drv_n));
endmodule

// File: tb/pipelined_bus_arbiter_tb.sv
`timescale 1ns/1ps
module pipelined_bus_arbiter_tb;
  localparam int N = 4;
  localparam int ROWS = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pend = '0, fin = '0;
  logic irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1;
  logic [N-1:0] req_n, gnt_n, frame_drv_n;
  logic frame_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pipelined_bus_arbiter #(.NUM_MASTERS(N), .PARK_ID(0)) u_dut (
    .clk(clk), .rst(rst), .xfer_pending(pend), .final_phase(fin),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .req_n(req_n), .gnt_n(gnt_n), .frame_drv_n(frame_drv_n), .frame_n(frame_n));

  // {pending, final, irdy_n, exp gnt_n, exp frame_drv_n, exp req_n}; bit 3 = master 3
  localparam logic [20:0] VEC [ROWS] = '{
    21'b0110_0000_1_1110_1111_1001,
    21'b0110_0000_1_1101_1111_1001,
    21'b0110_0000_1_1101_1101_1011,
    21'b0100_0000_1_1011_1101_1011,
    21'b0100_0000_0_1011_1101_1011,
    21'b0100_0010_1_1011_1111_1011,
    21'b0100_0000_0_1011_1111_1011,
    21'b0100_0000_1_1011_1011_1111,
    21'b0000_0000_1_1110_1011_1111,
    21'b0000_0100_1_1110_1111_1111,
    21'b1001_0000_1_1110_1110_0111,
    21'b1000_0000_1_0111_1110_0111,
    21'b0000_0000_1_0111_1110_1111,
    21'b0000_0000_1_1110_1110_1111,
    21'b1000_0001_1_1110_1111_0111,
    21'b1000_0000_1_0111_1111_0111,
    21'b1000_0000_1_0111_0111_1111,
    21'b0101_0000_1_1110_0111_1010,
    21'b0101_0000_1_1110_0111_1010,
    21'b0100_0000_1_1110_0111_1011,
    21'b0100_0000_1_1011_0111_1011
  };

  function automatic string row_tag(int r);
    case (r)
      0, 1:    return "R1/R3 request then first grant";
      2, 7:    return "R6 frame on edge after idle";
      3:       return "R4 grant moves during transfer";
      4, 6:    return "R5 irdy holds bus busy";
      5, 9:    return "R9 frame held until final phase";
      8, 10:   return "R10 park on default";
      11, 15:  return "R3 round-robin order";
      12:      return "R4 grant held while bus busy";
      13, 20:  return "R7 dropped request regrants";
      14:      return "R8 no start after grant removed";
      16:      return "R6 start after regrant";
      default: return "R2/R3 single grant after park";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] p, logic [N-1:0] f, logic irdy, logic devsel);
    @(negedge clk);
    pend = p; fin = f; irdy_n = irdy; devsel_n = devsel;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R6 watchdog: finished=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R10", "reset grant park", gnt_n, 4'b1110);
    check("R1", "reset requests", req_n, 4'b1111);
    check("R2", "reset frame", {3'b000, frame_n}, 4'b0001);
    @(negedge clk);
    rst = 1'b0;

    for (int r = 0; r < ROWS; r++) begin
      step(VEC[r][20:17], VEC[r][16:13], VEC[r][12], 1'b1);
      check(row_tag(r), "gnt_n", gnt_n, VEC[r][11:8]);
      check(row_tag(r), "frame_drv_n", frame_drv_n, VEC[r][7:4]);
      check(row_tag(r), "req_n", req_n, VEC[r][3:0]);
    end
    check("R2", "resolved frame low with owner 3", {3'b000, frame_n}, 4'b0000);

    // Directed: reset mid-transaction, then devsel keeps the bus busy.
    @(negedge clk);
    rst = 1'b1; pend = '0; fin = '0;
    @(posedge clk); #1;
    check("R10", "second reset grant", gnt_n, 4'b1110);
    check("R9", "reset clears frame", frame_drv_n, 4'b1111);
    @(negedge clk);
    rst = 1'b0;
    step(4'b0010, 4'b0000, 1'b1, 1'b1);
    check("R1", "request one edge after pending", req_n, 4'b1101);
    check("R10", "still parked", gnt_n, 4'b1110);
    step(4'b0010, 4'b0000, 1'b1, 1'b0);
    check("R3", "grant to master 1 from index 0", gnt_n, 4'b1101);
    check("R5", "no start yet", frame_drv_n, 4'b1111);
    step(4'b0010, 4'b0000, 1'b1, 1'b0);
    check("R5", "devsel low blocks start", frame_drv_n, 4'b1111);
    step(4'b0010, 4'b0000, 1'b1, 1'b1);
    check("R6", "start right after devsel release", frame_drv_n, 4'b1101);
    check("R6", "resolved frame", {3'b000, frame_n}, 4'b0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule